// File: doc/BRIEF.md
# Glitch-Free Clock Output Stop Controller

This block drives a group of differential clock lanes from one reference clock and lets an asynchronous, active-low stop request freeze the lanes cleanly. Each lane has a true and a complement level plus a drive-enable that models a tri-stated output pair. All lanes toggle on every reference edge, so an output runs at half the reference rate and every lane is in phase with every other.

The stop request is synchronized and then filtered, and it only counts as accepted once two consecutive samples agree. The samples are taken on the rising edges of the complement output. When a stop is accepted, the lanes selected by a per-lane mask finish their current phase and park. They park either high/low while still driven, or low on both sides with the drive released, depending on a mode bit. When the request is withdrawn, the parked lanes restart together, in step with the lanes that never stopped. In the undriven mode the drive returns before the first restarted edge.

Top module: `clk_stop_ctrl`

## Requirements
- R1: During reset every lane has drive-enable high, true low and complement high. After reset every lane toggles on each reference rising edge, with true high after the first edge following reset release.
- R2: The request is sampled on the reference edges where the true outputs fall, which are the complement rising edges. A change takes effect only after two consecutive samples agree. A low pulse of one reference cycle has no effect, and no lane halts within four reference edges of the request falling.
- R3: Once a stop is accepted, every selected lane halts at a phase boundary, and all selected lanes park on the same edge.
- R4: A lane whose mask bit is 0 keeps toggling during a stop. The mask and the mode bit are captured when the stop is accepted, so later changes to them do not affect lanes that are already parked.
- R5: With the mode bit 0, a parked lane holds true = 1, complement = 0 and drive-enable = 1.
- R6: With the mode bit 1, a parked lane holds true = 0, complement = 0 and drive-enable = 0.
- R7: After the request is released, all parked lanes resume on the same edge, between 4 and 12 reference cycles after release (2 to 6 output periods). They resume in phase with the lanes that kept running.
- R8: In mode 1, drive-enable returns at least one reference cycle before the first resumed edge, with true = 0 and complement = 1 in that interval.
- R9: No runt pulses appear: every level lasts at least one reference cycle. A driven lane always has true different from complement, and an undriven lane has both levels low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| stopReqN | input | 1 | Asynchronous stop request, active low |
| laneStopMask | input | LANES | 1 = lane may be stopped |
| parkUndriven | input | 1 | Park mode: 0 = driven high/low, 1 = released low |
| clkTrue | output | LANES | True level of each lane |
| clkComp | output | LANES | Complement level of each lane |
| driveEn | output | LANES | Drive-enable of each lane |

## Verification
The assertions are checked on every cycle. They cover the level relation between true, complement and drive-enable, and they require that a lane can hold its level only while the control has it held. They also check that the accepted request changes only on a sampling edge, and that the restart phase is bounded. The bench scenarios show the rest: that a single-cycle request pulse is filtered out, and the park levels in each mode. They also show that the mask is captured, the measured restart latency, that all lanes restart on the same edge and in phase with the free lanes, and that drive returns early in the undriven mode.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_STOPPING,
    ST_PARKED,
    ST_RESUME
  } stopState_e;

  // Strobes from control to the lane datapath
  typedef struct packed {
    logic hold;      // selected lanes keep their park/prep levels this edge
    logic prep;      // undriven mode: drive again ahead of the restart edge
    logic undriven;  // captured park mode
  } laneStrb_t;

endpackage

// File: rtl/clk_stop_filter.sv
module clk_stop_filter (
  input  logic clk,
  input  logic rst,
  input  logic stopReqN,
  input  logic sampleEn,
  output logic stopAcc
);
  logic syncA, syncB, lastSample, acceptedN;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA      <= 1'b1;
      syncB      <= 1'b1;
      lastSample <= 1'b1;
      acceptedN  <= 1'b1;
    end else begin
      syncA <= stopReqN;
      syncB <= syncA;
      if (sampleEn) begin
        lastSample <= syncB;
        if (syncB == lastSample) acceptedN <= syncB;
      end
    end
  end

  assign stopAcc = ~acceptedN;

  // R2
  accept_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (acceptedN != $past(acceptedN))) |-> $past(sampleEn));

endmodule

// File: rtl/clk_stop_control.sv
module clk_stop_control
  import clk_stop_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stopReqN,
  input  logic             phase,
  input  logic [LANES-1:0] laneMask,
  input  logic             parkUndriven,
  output laneStrb_t        strb,
  output logic [LANES-1:0] laneHeld
);
  stopState_e       state;
  logic             stopAcc;
  logic             modeQ;
  logic [1:0]       resCnt;
  logic             stopCond, resumeCond, resumeNow;

  // Sample the request on edges where the true side falls (complement rises)
  clk_stop_filter uFilter (
    .clk      (clk),
    .rst      (rst),
    .stopReqN (stopReqN),
    .sampleEn (phase),
    .stopAcc  (stopAcc)
  );

  // Driven mode parks on a rising true edge, undriven mode on a falling one
  assign stopCond   = (phase == modeQ);
  assign resumeCond = (phase != modeQ);
  assign resumeNow  = (state == ST_RESUME) && (resCnt != 2'd0) && resumeCond;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      laneHeld <= '0;
      modeQ    <= 1'b0;
      resCnt   <= 2'd0;
    end else begin
      unique case (state)
        ST_RUN: if (stopAcc) begin
          laneHeld <= laneMask;
          modeQ    <= parkUndriven;
          state    <= ST_STOPPING;
        end
        ST_STOPPING: if (stopCond) state <= ST_PARKED;
        ST_PARKED: if (!stopAcc) begin
          state  <= ST_RESUME;
          resCnt <= 2'd0;
        end
        ST_RESUME: begin
          resCnt <= resCnt + 2'd1;
          if (resumeNow) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strb.hold = ((state == ST_STOPPING) && stopCond) || (state == ST_PARKED) ||
                ((state == ST_RESUME) && !resumeNow);
    strb.prep     = (state == ST_RESUME) && modeQ;
    strb.undriven = modeQ;
  end

  // R7
  resume_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESUME) |-> (resCnt <= 2'd2));

endmodule

// File: rtl/clk_stop_datapath.sv
module clk_stop_datapath
  import clk_stop_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  laneStrb_t        strb,
  input  logic [LANES-1:0] laneHeld,
  output logic             phase,
  output logic [LANES-1:0] trueQ,
  output logic [LANES-1:0] compQ,
  output logic [LANES-1:0] oeQ
);
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  for (genvar i = 0; i < LANES; i++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst) begin
        trueQ[i] <= 1'b0;
        compQ[i] <= 1'b1;
        oeQ[i]   <= 1'b1;
      end else if (strb.hold && laneHeld[i]) begin
        if (!strb.undriven) begin
          trueQ[i] <= 1'b1;
          compQ[i] <= 1'b0;
          oeQ[i]   <= 1'b1;
        end else begin
          trueQ[i] <= 1'b0;
          compQ[i] <= strb.prep;
          oeQ[i]   <= strb.prep;
        end
      end else begin
        trueQ[i] <= ~phase;
        compQ[i] <= phase;
        oeQ[i]   <= 1'b1;
      end
    end

    // R9
    driven_pair_chk: assert property (@(posedge clk) disable iff (rst)
      oeQ[i] |-> (trueQ[i] != compQ[i]));

    // R6
    undriven_low_chk: assert property (@(posedge clk) disable iff (rst)
      !oeQ[i] |-> (!trueQ[i] && !compQ[i]));

    // R4
    lane_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (trueQ[i] == $past(trueQ[i]))) |->
        ($past(strb.hold) && $past(laneHeld[i])));
  end

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stopReqN,
  input  logic [LANES-1:0] laneStopMask,
  input  logic             parkUndriven,
  output logic [LANES-1:0] clkTrue,
  output logic [LANES-1:0] clkComp,
  output logic [LANES-1:0] driveEn
);
  laneStrb_t        strb;
  logic [LANES-1:0] laneHeld;
  logic             phase;

  clk_stop_control #(.LANES(LANES)) uCtrl (
    .clk          (clk),
    .rst          (rst),
    .stopReqN     (stopReqN),
    .phase        (phase),
    .laneMask     (laneStopMask),
    .parkUndriven (parkUndriven),
    .strb         (strb),
    .laneHeld     (laneHeld)
  );

  clk_stop_datapath #(.LANES(LANES)) uPath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .laneHeld (laneHeld),
    .phase    (phase),
    .trueQ    (clkTrue),
    .compQ    (clkComp),
    .oeQ      (driveEn)
  );

endmodule

// File: tb/tb_clk_stop_ctrl.sv
`timescale 1ns/1ps
module tb_clk_stop_ctrl;
  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stopReqN = 1'b1;
  logic         parkUndriven = 1'b0;
  logic [L-1:0] laneStopMask = '1;
  logic [L-1:0] clkTrue, clkComp, driveEn;

  int chkCount = 0;
  int errCount = 0;
  int cyc = 0;

  typedef struct {
    int           due;
    logic [L-1:0] m, t, c, oe;
    string        req;
  } exp_t;
  exp_t q[$];

  clk_stop_ctrl #(.LANES(L)) dut (
    .clk(clk), .rst(rst), .stopReqN(stopReqN), .laneStopMask(laneStopMask),
    .parkUndriven(parkUndriven), .clkTrue(clkTrue), .clkComp(clkComp), .driveEn(driveEn)
  );

  always #4 clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver side: push expectations
  task automatic pushVal(input int due, input logic [L-1:0] m, input logic [L-1:0] t,
                         input logic [L-1:0] c, input logic [L-1:0] oe, input string req);
    exp_t e;
    e.due = due; e.m = m; e.t = t; e.c = c; e.oe = oe; e.req = req;
    q.push_back(e);
  endtask

  // Free-running level after edge number due: true high on odd edges
  task automatic pushFree(input int due, input logic [L-1:0] m, input string req);
    logic [L-1:0] t;
    t = due[0] ? '1 : '0;
    pushVal(due, m, t, ~t, '1, req);
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      check(((clkTrue & e.m) == (e.t & e.m)) && ((clkComp & e.m) == (e.c & e.m)) &&
            ((driveEn & e.m) == (e.oe & e.m)) && (e.due == cyc), e.req,
            {20'd0, clkTrue & e.m, clkComp & e.m, driveEn & e.m},
            {20'd0, e.t & e.m, e.c & e.m, e.oe & e.m});
    end
  end

  // R9: level relations and minimum phase width, every cycle
  logic [L-1:0] prevT;
  int runLen [L];
  always @(negedge clk) begin
    if (rst) begin
      prevT = clkTrue;
      for (int i = 0; i < L; i++) runLen[i] = 1;
    end else begin
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < L; i++) begin
        if (driveEn[i]) ok &= (clkTrue[i] != clkComp[i]);
        else            ok &= (!clkTrue[i] && !clkComp[i]);
        if (clkTrue[i] != prevT[i]) begin
          ok &= (runLen[i] >= 1);
          runLen[i] = 1;
        end else runLen[i]++;
      end
      prevT = clkTrue;
      check(ok, "R9 level relation / width", {8'd0, clkTrue, clkComp, driveEn}, 32'd0);
    end
  end

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", chkCount, errCount);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    chkCount++;
    errCount++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish();
  end

  initial begin
    int k0, trueCyc, oeCyc;
    waitEdges(3);
    // R1: reset state
    check(driveEn == '1 && clkTrue == '0 && clkComp == '1, "R1 reset",
          {20'd0, clkTrue, clkComp, driveEn}, {20'd0, 4'h0, 4'hF, 4'hF});
    rst = 1'b0;
    for (int k = 1; k <= 8; k++) pushFree(cyc + k, '1, "R1 free run");
    waitEdges(10);

    // R2: single-cycle pulse is filtered out
    laneStopMask = '1; parkUndriven = 1'b0;
    stopReqN = 1'b0;
    waitEdges(1);
    stopReqN = 1'b1;
    for (int k = 1; k <= 20; k++) pushFree(cyc + k, '1, "R2 pulse ignored");
    waitEdges(24);

    // Driven park, lane 3 exempt
    laneStopMask = 4'b0111; parkUndriven = 1'b0;
    stopReqN = 1'b0;
    for (int k = 1; k <= 4; k++) pushFree(cyc + k, '1, "R2 no early halt");
    waitEdges(14);
    laneStopMask = 4'b1111;  // captured mask must stay in force
    for (int k = 1; k <= 4; k++) begin
      pushVal(cyc + k, 4'b0111, '1, '0, '1, "R5/R3 driven park");
      pushFree(cyc + k, 4'b1000, "R4 exempt lane runs");
    end
    waitEdges(6);
    k0 = cyc;
    stopReqN = 1'b1;
    trueCyc = -1;
    for (int n = 0; n < 24 && trueCyc < 0; n++) begin
      @(negedge clk);
      if (clkTrue[0] != 1'b1) begin
        trueCyc = cyc;
        check(clkTrue[2:0] == 3'b000, "R7 simultaneous resume", {29'd0, clkTrue[2:0]}, 32'd0);
      end
    end
    check(trueCyc - k0 >= 4 && trueCyc - k0 <= 12, "R7 resume latency", trueCyc - k0, 8);
    for (int k = 1; k <= 6; k++) pushFree(cyc + k, '1, "R7 in phase after resume");
    waitEdges(10);

    // Undriven park on lanes 1 and 3
    laneStopMask = 4'b1010; parkUndriven = 1'b1;
    stopReqN = 1'b0;
    waitEdges(14);
    parkUndriven = 1'b0;  // captured mode must stay in force
    for (int k = 1; k <= 4; k++) begin
      pushVal(cyc + k, 4'b1010, '0, '0, '0, "R6 undriven park");
      pushFree(cyc + k, 4'b0101, "R4 unmasked lanes run");
    end
    waitEdges(6);
    k0 = cyc;
    stopReqN = 1'b1;
    trueCyc = -1; oeCyc = -1;
    for (int n = 0; n < 24 && trueCyc < 0; n++) begin
      @(negedge clk);
      if (oeCyc < 0 && driveEn[1]) begin
        oeCyc = cyc;
        check(!clkTrue[1] && clkComp[1] && driveEn[3], "R8 prep levels",
              {29'd0, clkTrue[1], clkComp[1], driveEn[3]}, 32'd3);
      end
      if (clkTrue[1]) begin
        trueCyc = cyc;
        check(clkTrue[3] == 1'b1, "R7 simultaneous resume", {31'd0, clkTrue[3]}, 32'd1);
      end
    end
    check(oeCyc >= 0 && oeCyc < trueCyc, "R8 drive before edge", oeCyc, trueCyc - 1);
    check(trueCyc - k0 >= 4 && trueCyc - k0 <= 12, "R7 resume latency", trueCyc - k0, 8);
    for (int k = 1; k <= 6; k++) pushFree(cyc + k, '1, "R7 in phase after resume");
    waitEdges(10);

    // Empty mask: stop has no visible effect
    laneStopMask = '0;
    stopReqN = 1'b0;
    for (int k = 1; k <= 20; k++) pushFree(cyc + k, '1, "R4 empty mask");
    waitEdges(22);
    stopReqN = 1'b1;
    for (int k = 1; k <= 12; k++) pushFree(cyc + k, '1, "R4 empty mask release");
    waitEdges(16);
    finish();
  end
endmodule